// File: doc/BRIEF.md
# Raster Video Address Generator

This block produces the word address that a bitmap display fetches from memory, along with the horizontal and vertical timing windows that frame the picture. A horizontal counter advances on each pixel tick. A vertical counter advances once per horizontal wrap. Each axis has its own period and its own programmable compare values for border, display and sync. While both axes are inside their display windows, the block issues fetch strobes and steps a running word address.

At the end of every line that lies in the vertical display window, a programmable inter-line offset is added to that running address. At the start of vertical display the address is reloaded from a programmable frame base. The live address and both counters can be read back through the register port.

A CPU programs the block through a single-cycle write port. Reads are combinational: `reg_rdata` follows `reg_addr` in the same cycle. `fetch_stb` is a one-cycle pulse that carries `fetch_addr`. There is no back-pressure. The memory side must take each strobed address in the cycle it appears. The fine-scroll and mode outputs are plain levels for the downstream pixel path.

Top module: `raster_addr_gen`

## Requirements
- R1: After reset, every register, both counters and the running address are zero. `fetch_stb`, `disp_en`, `bord_en`, `hsync` and `vsync` are low.
- R2: Register map, with 16-bit data and 5-bit word index:
  - 0: base low, bits [15:0] of the base.
  - 1: base high, bits [AW-1:16].
  - 4: line length in words.
  - 5: inter-line offset in words.
  - 6: fine scroll, 4 bits.
  - 7: mode. Bit 0 is interlace; bit 1 selects 640 wide.
  - 8 to 14: horizontal set, HW bits each. The order is period, border begin, border end, display begin, display end, sync begin, sync end.
  - 16 to 22: the same set for the vertical axis, VW bits each.
  - A write takes effect on the next cycle. A writable register reads back its value masked to its width. Indices 24 to 31 read zero.
- R3: On a cycle with `pix_tick`, the horizontal counter steps by one. When it is already greater than or equal to its period, it returns to zero instead; this is the horizontal wrap. The vertical counter steps only on a horizontal wrap, with the same wrap rule against its own period. Without `pix_tick`, neither counter changes.
- R4: An axis is inside a window when begin <= count < end.
  - `hsync` and `vsync` follow the sync windows of their own axis.
  - `disp_en` is high only when both axes are inside their display windows.
  - `bord_en` is high when both axes are inside their border windows and `disp_en` is low.
- R5: `fetch_stb` is high only on a `pix_tick` cycle with `disp_en` high. The number of fetches per line is limited. The limit is the line length, plus one extra word when the fine scroll is nonzero.
- R6: Each fetch advances the running address by one, modulo 2^AW. `fetch_addr` shows the running address.
- R7: On a horizontal wrap of a line whose vertical count is inside the vertical display window, the inter-line offset is added to the running address. If a fetch falls in the same cycle, the running address grows by the offset plus one.
- R8: On a horizontal wrap whose next vertical count equals the vertical display begin, the running address is loaded from the base. The load overrides any fetch step or offset in that cycle. Writing the base does not disturb the running address at any other time.
- R9: Indices 2 and 3 read the running address, low and high parts. Index 15 reads the live horizontal count and index 23 the live vertical count. Writes to these four indices are ignored.
- R10: `fine_scroll`, `interlace` and `wide_mode` show the scroll register and mode bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_tick | input | 1 | Pixel-clock enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| fetch_addr | output | AW (22) | Running word address |
| fetch_stb | output | 1 | Fetch pulse for `fetch_addr` |
| disp_en | output | 1 | Inside both display windows |
| bord_en | output | 1 | Inside both border windows, outside display |
| hsync | output | 1 | Horizontal sync window |
| vsync | output | 1 | Vertical sync window |
| fine_scroll | output | 4 | Fine horizontal scroll value |
| interlace | output | 1 | Interlace mode bit |
| wide_mode | output | 1 | 640-wide mode bit |

## Verification
The main collision is the last fetch of a line landing on the horizontal wrap. That wrap also adds the inter-line offset, and it may also be the frame-start reload. The bench provokes it by programming the horizontal display end past the horizontal period, so display is still open at the wrap. It also sets the vertical display window from zero to beyond the vertical period, so every wrap is both a displayed-line end and, once per frame, a reload. A behavioural model applies the stated precedence: reload first, then offset plus fetch. The bench compares `fetch_addr`, `fetch_stb` and read-back on every clock, including while random writes to the read-only indices and period changes below the live counters are in flight.

// File: rtl/rvag_pkg.sv
`timescale 1ns/1ps
package rvag_pkg;
  localparam int DW = 16;
  localparam int NCFG = 7;
  // register indices
  localparam logic [4:0] IX_BASE_LO = 5'd0;
  localparam logic [4:0] IX_BASE_HI = 5'd1;
  localparam logic [4:0] IX_ADDR_LO = 5'd2;
  localparam logic [4:0] IX_ADDR_HI = 5'd3;
  localparam logic [4:0] IX_LEN     = 5'd4;
  localparam logic [4:0] IX_SKIP    = 5'd5;
  localparam logic [4:0] IX_SCROLL  = 5'd6;
  localparam logic [4:0] IX_MODE    = 5'd7;
  localparam logic [4:0] IX_HBASE   = 5'd8;
  localparam logic [4:0] IX_HCNT    = 5'd15;
  localparam logic [4:0] IX_VBASE   = 5'd16;
  localparam logic [4:0] IX_VCNT    = 5'd23;
  // order of compare values inside one axis set
  localparam int C_PER  = 0;
  localparam int C_BBEG = 1;
  localparam int C_BEND = 2;
  localparam int C_DBEG = 3;
  localparam int C_DEND = 4;
  localparam int C_SBEG = 5;
  localparam int C_SEND = 6;
endpackage

// File: rtl/rvag_regs.sv
`timescale 1ns/1ps
module rvag_regs
  import rvag_pkg::*;
#(
  parameter int AW = 22,
  parameter int HW = 10,
  parameter int VW = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [4:0]               addr,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  input  logic [AW-1:0]            live_addr,
  input  logic [HW-1:0]            live_h,
  input  logic [VW-1:0]            live_v,
  output logic [AW-1:0]            base,
  output logic [DW-1:0]            line_len,
  output logic [DW-1:0]            line_skip,
  output logic [3:0]               scroll,
  output logic [1:0]               mode,
  output logic [NCFG-1:0][HW-1:0]  hcfg,
  output logic [NCFG-1:0][VW-1:0]  vcfg
);
  localparam int BHW = AW - DW;

  logic [DW-1:0]  base_lo;
  logic [BHW-1:0] base_hi;

  assign base = {base_hi, base_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_lo   <= '0;
      base_hi   <= '0;
      line_len  <= '0;
      line_skip <= '0;
      scroll    <= '0;
      mode      <= '0;
    end else if (we) begin
      case (addr)
        IX_BASE_LO: base_lo   <= wdata;
        IX_BASE_HI: base_hi   <= wdata[BHW-1:0];
        IX_LEN:     line_len  <= wdata;
        IX_SKIP:    line_skip <= wdata;
        IX_SCROLL:  scroll    <= wdata[3:0];
        IX_MODE:    mode      <= wdata[1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hcfg[g] <= '0;
        vcfg[g] <= '0;
      end else if (we) begin
        if (addr == IX_HBASE + 5'(g)) hcfg[g] <= wdata[HW-1:0];
        if (addr == IX_VBASE + 5'(g)) vcfg[g] <= wdata[VW-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      IX_BASE_LO: rdata = base_lo;
      IX_BASE_HI: rdata = DW'(base_hi);
      IX_ADDR_LO: rdata = live_addr[DW-1:0];
      IX_ADDR_HI: rdata = DW'(live_addr[AW-1:DW]);
      IX_LEN:     rdata = line_len;
      IX_SKIP:    rdata = line_skip;
      IX_SCROLL:  rdata = DW'(scroll);
      IX_MODE:    rdata = DW'(mode);
      IX_HCNT:    rdata = DW'(live_h);
      IX_VCNT:    rdata = DW'(live_v);
      default: begin
        if (addr[4:3] == 2'b01) rdata = DW'(hcfg[addr[2:0]]);
        else if (addr[4:3] == 2'b10) rdata = DW'(vcfg[addr[2:0]]);
      end
    endcase
  end
endmodule

// File: rtl/rvag_axis.sv
`timescale 1ns/1ps
module rvag_axis
  import rvag_pkg::*;
#(
  parameter int W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   step,
  input  logic [NCFG-1:0][W-1:0] cfg,
  output logic [W-1:0]           cnt,
  output logic [W-1:0]           cnt_next,
  output logic                   wrap,
  output logic                   in_bord,
  output logic                   in_disp,
  output logic                   in_sync
);
  logic at_end;

  assign at_end   = (cnt >= cfg[C_PER]);
  assign wrap     = step && at_end;
  assign cnt_next = at_end ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= cnt_next;
  end

  assign in_bord = (cnt >= cfg[C_BBEG]) && (cnt < cfg[C_BEND]);
  assign in_disp = (cnt >= cfg[C_DBEG]) && (cnt < cfg[C_DEND]);
  assign in_sync = (cnt >= cfg[C_SBEG]) && (cnt < cfg[C_SEND]);
endmodule

// File: rtl/rvag_addr.sv
`timescale 1ns/1ps
module rvag_addr
  import rvag_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          disp_en,
  input  logic          line_end,
  input  logic          line_shown,
  input  logic          frame_start,
  input  logic          extra_word,
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] line_len,
  input  logic [DW-1:0] line_skip,
  output logic [AW-1:0] addr,
  output logic          fetch
);
  localparam int CW = DW + 1;

  logic [CW-1:0] words;
  logic [CW-1:0] limit;
  logic [AW-1:0] step_amt;

  assign limit    = {1'b0, line_len} + CW'(extra_word);
  assign fetch    = tick && disp_en && (words < limit);
  assign step_amt = AW'(fetch) + (line_shown ? AW'(line_skip) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr  <= '0;
      words <= '0;
    end else if (frame_start) begin
      addr  <= base;
      words <= '0;
    end else if (line_end) begin
      addr  <= addr + step_amt;
      words <= '0;
    end else if (fetch) begin
      addr  <= addr + 1'b1;
      words <= words + 1'b1;
    end
  end
endmodule

// File: rtl/raster_addr_gen.sv
`timescale 1ns/1ps
module raster_addr_gen
  import rvag_pkg::*;
#(
  parameter int AW = 22,
  parameter int HW = 10,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_tick,
  input  logic          reg_we,
  input  logic [4:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic [AW-1:0] fetch_addr,
  output logic          fetch_stb,
  output logic          disp_en,
  output logic          bord_en,
  output logic          hsync,
  output logic          vsync,
  output logic [3:0]    fine_scroll,
  output logic          interlace,
  output logic          wide_mode
);
  logic [AW-1:0]            base;
  logic [DW-1:0]            line_len, line_skip;
  logic [1:0]               mode;
  logic [NCFG-1:0][HW-1:0]  hcfg;
  logic [NCFG-1:0][VW-1:0]  vcfg;
  logic [HW-1:0]            hcnt, hnext_unused;
  logic [VW-1:0]            vcnt, vnext;
  logic                     hwrap, vwrap_unused;
  logic                     hb, hd, vb, vd;
  logic                     frame_start;

  rvag_regs #(.AW(AW), .HW(HW), .VW(VW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .live_addr(fetch_addr), .live_h(hcnt), .live_v(vcnt),
    .base(base), .line_len(line_len), .line_skip(line_skip),
    .scroll(fine_scroll), .mode(mode), .hcfg(hcfg), .vcfg(vcfg)
  );

  rvag_axis #(.W(HW)) u_hax (
    .clk(clk), .rst_n(rst_n), .step(pix_tick), .cfg(hcfg),
    .cnt(hcnt), .cnt_next(hnext_unused), .wrap(hwrap),
    .in_bord(hb), .in_disp(hd), .in_sync(hsync)
  );

  rvag_axis #(.W(VW)) u_vax (
    .clk(clk), .rst_n(rst_n), .step(hwrap), .cfg(vcfg),
    .cnt(vcnt), .cnt_next(vnext), .wrap(vwrap_unused),
    .in_bord(vb), .in_disp(vd), .in_sync(vsync)
  );

  assign disp_en     = hd && vd;
  assign bord_en     = hb && vb && !disp_en;
  assign frame_start = hwrap && (vnext == vcfg[C_DBEG]);
  assign interlace   = mode[0];
  assign wide_mode   = mode[1];

  rvag_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .tick(pix_tick), .disp_en(disp_en),
    .line_end(hwrap), .line_shown(vd), .frame_start(frame_start),
    .extra_word(fine_scroll != 4'd0), .base(base),
    .line_len(line_len), .line_skip(line_skip),
    .addr(fetch_addr), .fetch(fetch_stb)
  );
endmodule

// File: rtl/raster_addr_gen_chk.sv
`timescale 1ns/1ps
module raster_addr_gen_chk #(
  parameter int AW = 22,
  parameter int HW = 10,
  parameter int VW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_tick,
  input logic          fetch_stb,
  input logic [AW-1:0] fetch_addr,
  input logic          disp_en,
  input logic          bord_en,
  input logic [HW-1:0] hcnt,
  input logic [VW-1:0] vcnt,
  input logic          hwrap,
  input logic          frame_start,
  input logic [AW-1:0] base
);
  // R5
  a_r5_fetch_in_disp: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |-> (disp_en && pix_tick));
  // R4
  a_r4_bord_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_en && bord_en));
  // R3
  a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_tick |=> ($stable(hcnt) && $stable(vcnt)));
  // R3
  a_r3_v_only_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_tick && !hwrap) |=> $stable(vcnt));
  // R6
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stb && !hwrap) |=> (fetch_addr == ($past(fetch_addr) + 1'b1)));
  // R8
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (fetch_addr == $past(base)));
endmodule

bind raster_addr_gen raster_addr_gen_chk #(.AW(AW), .HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .fetch_stb(fetch_stb),
  .fetch_addr(fetch_addr), .disp_en(disp_en), .bord_en(bord_en),
  .hcnt(hcnt), .vcnt(vcnt), .hwrap(hwrap), .frame_start(frame_start),
  .base(base)
);

// File: tb/raster_addr_gen_bench.sv
`timescale 1ns/1ps
module raster_addr_gen_bench;
  localparam int AW = 22;
  localparam int HW = 10;
  localparam int VW = 11;
  localparam int AMASK = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_tick = 1'b0, reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [AW-1:0] fetch_addr;
  logic fetch_stb, disp_en, bord_en, hsync, vsync, interlace, wide_mode;
  logic [3:0] fine_scroll;

  always #2 clk = ~clk;

  raster_addr_gen #(.AW(AW), .HW(HW), .VW(VW)) u_raster_addr_gen (
    .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fetch_addr(fetch_addr), .fetch_stb(fetch_stb), .disp_en(disp_en),
    .bord_en(bord_en), .hsync(hsync), .vsync(vsync),
    .fine_scroll(fine_scroll), .interlace(interlace), .wide_mode(wide_mode)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  // behavioural reference state
  int m_reg [32];
  int m_hc = 0, m_vc = 0, m_addr = 0, m_wc = 0;

  function automatic int wmask(int idx);
    if (idx == 1) return (1 << (AW - 16)) - 1;
    if (idx == 6) return 15;
    if (idx == 7) return 3;
    if (idx >= 8 && idx <= 14) return (1 << HW) - 1;
    if (idx >= 16 && idx <= 22) return (1 << VW) - 1;
    if (idx == 0 || idx == 4 || idx == 5) return 16'hFFFF;
    return 0;
  endfunction

  function automatic int m_read(int idx);
    if (idx == 2) return m_addr & 16'hFFFF;
    if (idx == 3) return m_addr >> 16;
    if (idx == 15) return m_hc;
    if (idx == 23) return m_vc;
    return m_reg[idx];
  endfunction

  function automatic bit inwin(int c, int b, int e);
    return (c >= b) && (c < e);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit tk, bit we, int wa, int wd, int ra);
    bit hd, vd, hb, vb, dsp, brd, fet, hwrap, fst;
    int lim, vnext;
    @(negedge clk);
    pix_tick = tk; reg_we = we; reg_addr = 5'(wa); reg_wdata = 16'(wd);
    reg_addr = we ? 5'(wa) : 5'(ra);
    #1;
    hd  = inwin(m_hc, m_reg[11], m_reg[12]);
    hb  = inwin(m_hc, m_reg[9],  m_reg[10]);
    vd  = inwin(m_vc, m_reg[19], m_reg[20]);
    vb  = inwin(m_vc, m_reg[17], m_reg[18]);
    dsp = hd && vd;
    brd = hb && vb && !dsp;
    lim = m_reg[4] + ((m_reg[6] != 0) ? 1 : 0);
    fet = tk && dsp && (m_wc < lim);
    check(disp_en == dsp, "R4 disp_en", int'(disp_en), int'(dsp));
    check(bord_en == brd, "R4 bord_en", int'(bord_en), int'(brd));
    check(hsync == inwin(m_hc, m_reg[13], m_reg[14]), "R4 hsync", int'(hsync), int'(inwin(m_hc, m_reg[13], m_reg[14])));
    check(vsync == inwin(m_vc, m_reg[21], m_reg[22]), "R4 vsync", int'(vsync), int'(inwin(m_vc, m_reg[21], m_reg[22])));
    check(fetch_stb == fet, "R5 fetch_stb", int'(fetch_stb), int'(fet));
    check(int'(fetch_addr) == m_addr, "R6/R7/R8 fetch_addr", int'(fetch_addr), m_addr);
    if (!we) check(int'(reg_rdata) == m_read(ra), "R2/R9 reg_rdata", int'(reg_rdata), m_read(ra));
    check(int'(fine_scroll) == m_reg[6] && interlace == m_reg[7][0] && wide_mode == m_reg[7][1],
          "R10 mode pins", {fine_scroll, interlace, wide_mode}, {m_reg[6][3:0], m_reg[7][0], m_reg[7][1]});
    @(posedge clk);
    hwrap = tk && (m_hc >= m_reg[8]);
    vnext = (m_vc >= m_reg[16]) ? 0 : m_vc + 1;
    fst   = hwrap && (vnext == m_reg[19]);
    if (fst) begin
      m_addr = (m_reg[1] << 16) | m_reg[0]; m_wc = 0;
    end else if (hwrap) begin
      m_addr = (m_addr + (fet ? 1 : 0) + (vd ? m_reg[5] : 0)) & AMASK; m_wc = 0;
    end else if (fet) begin
      m_addr = (m_addr + 1) & AMASK; m_wc++;
    end
    if (tk) m_hc = hwrap ? 0 : m_hc + 1;
    if (hwrap) m_vc = vnext;
    if (we) m_reg[wa] = wd & wmask(wa);
  endtask

  task automatic wr(int a, int d);
    step(0, 1, a, d, 0);
  endtask

  task automatic run(int n, int density);
    for (int i = 0; i < n; i++) begin
      int ra = int'($urandom_range(0, 31));
      bit tk = ($urandom_range(0, 99) < density);
      if ($urandom_range(0, 15) == 0) begin
        // writes to the live read-only indices must be ignored (R9)
        int roi [4] = '{2, 3, 15, 23};
        step(tk, 1, roi[$urandom_range(0, 3)], int'($urandom_range(0, 65535)), 0);
      end else begin
        step(tk, 0, 0, 0, ra);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_reg[i] = 0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    // R1: reset state
    @(negedge clk); #1;
    check(fetch_addr == '0 && !fetch_stb && !hsync && !vsync, "R1 reset outputs",
          {fetch_stb, hsync, vsync}, 0);
    check(reg_rdata == 16'd0, "R1 reset read idx0", int'(reg_rdata), 0);
    // base near the top of the space so R6 wrap is reached
    wr(0, 16'hFFC0); wr(1, 16'hFFFF);
    wr(4, 8); wr(5, 5); wr(7, 16'h0003);
    wr(8, 19); wr(9, 1); wr(10, 18); wr(11, 3); wr(12, 15); wr(13, 16); wr(14, 18);
    wr(16, 9); wr(17, 0); wr(18, 9); wr(19, 2); wr(20, 7); wr(21, 8); wr(22, 9);
    wr(30, 16'h1234); // R2: unused index reads zero
    for (int a = 0; a < 32; a++) step(0, 0, 0, 0, a); // R2 full read-back sweep
    run(1500, 70);
    run(300, 0);      // R3 no tick: counters hold
    // R5: scroll adds a word; long line capped by window
    wr(6, 3); wr(4, 20);
    run(1500, 80);
    wr(4, 6);
    run(800, 100);
    // R7/R8 coincidence: display open across wrap, every line shown
    wr(12, 25); wr(19, 0); wr(20, 12); wr(0, 16'h0100); wr(1, 0);
    run(1500, 90);
    // live changes incl. periods below the running counters (R3)
    for (int k = 0; k < 40; k++) begin
      int idx = int'($urandom_range(4, 22));
      if (idx == 15) idx = 8;
      wr(idx, int'($urandom_range(0, 24)));
      run(60, 85);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule